// File: doc/BRIEF.md
# Resolution-Scaled Conversion Scheduler

This block paces a temperature converter from a slow timebase tick. Every conversion runs for a number of ticks set by a 2-bit resolution field. A separate 2-bit delay field sets the spacing between conversion starts as a multiple of that length, so the start-to-start period also grows with resolution. When a conversion finishes, the converter's raw 13-bit two's-complement result (LSB = 0.0625 °C) is captured into the temperature register. The low bits that the chosen resolution cannot resolve are cleared, and a one-cycle valid strobe is raised.

The resolution and delay fields are sampled when a conversion starts. A change made while a conversion is running therefore applies from the next start. A shutdown request never cuts a conversion short: the running conversion ends and delivers its result, and only then does the block go quiet. A request made between conversions takes effect at once. A wake request restarts conversions right away. The temperature register always holds the last completed result and reads zero until the first one completes. With the default parameter, one tick stands for about 30 ms and periods are rounded to whole ticks.

Top module: `conv_sched`

## Requirements
- R1: Reset behaviour.
  - While reset is asserted, the resolution and delay inputs are captured and a conversion starts at tick count zero.
  - After reset, `temp_o` is 0 and `valid_o` is 0.
  - `temp_o` stays 0 until the first conversion completes.
- R2: A conversion lasts `BASE_TICKS << res` ticks. With the default, resolution codes 00, 01, 10 and 11 take 1, 2, 4 and 8 ticks (9, 10, 11 and 12 bits plus sign).
- R3: Start-to-start period.
  - The period is the conversion length multiplied by 1, 2, 4 or 32 for delay codes 00, 01, 10 and 11.
  - Delay 00 means back-to-back conversions: busy never drops between them.
- R4: At completion the raw value is stored with its lowest 3, 2, 1 or 0 bits forced to zero, for resolution codes 00, 01, 10 and 11.
- R5: Result strobe and register hold.
  - Each completion gives exactly one `valid_o` pulse of one cycle. The new `temp_o` appears in the same cycle as the pulse.
  - `temp_o` holds its value between completions.
- R6: A resolution change made during a conversion does not alter that conversion's length or mask. It applies from the next start.
- R7: A shutdown request during a conversion lets that conversion complete and deliver its result. After that, no further conversions run, no strobe appears and `busy_o` is 0.
- R8: A shutdown request between conversions stops the block immediately, with no further result.
- R9: Wake requests.
  - A wake request in shutdown starts a new conversion at tick count zero, using the current field values.
  - A wake request cancels a pending shutdown.
  - If wake and shutdown are requested in the same cycle, wake wins.
- R10: `busy_o` is 1 from a conversion start until its completing tick, and 0 in the gap and in shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle timebase tick |
| res_sel_i | input | 2 | Resolution code (00 = 9 bits … 11 = 12 bits) |
| dly_sel_i | input | 2 | Start-period code (00 continuous, 01 ×2, 10 ×4, 11 ×32) |
| raw_i | input | DATA_W | Raw converter result, two's complement |
| shut_req_i | input | 1 | Request shutdown at the next conversion boundary |
| wake_req_i | input | 1 | Leave shutdown or cancel a pending one |
| busy_o | output | 1 | Conversion in progress |
| valid_o | output | 1 | One-cycle strobe on each completion |
| temp_o | output | DATA_W | Last completed, resolution-masked result |

## Verification
The bench changes the resolution part-way through a conversion. A design that sampled the field live would finish early, or apply the new mask to the old conversion.

It issues shutdown both in the middle of a conversion and in the idle gap. A design that stopped at once would lose the pending result. A design that waited for a boundary in the gap would produce one result too many.

It sends simultaneous wake and shutdown requests and checks that conversions keep running. It also checks that `busy_o` stays high throughout in continuous mode. A design with a dead cycle at each restart would show `busy_o` dropping or would produce late strobes.

// File: rtl/conv_pkg.sv
// Shared types for the conversion scheduler.
package conv_pkg;
    // Sequencer states: running conversions, or quiescent after shutdown.
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_SHUT = 1'b1
    } seq_st_t;

    // Shift that turns a delay code into a period multiplier (x1, x2, x4, x32).
    function automatic logic [2:0] dly_shift(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd0;
            2'd1:    return 3'd1;
            2'd2:    return 3'd2;
            default: return 3'd5;
        endcase
    endfunction
endpackage

// File: rtl/conv_timing.sv
// conv_timing: turns resolution and delay codes into a conversion length and a
// start-to-start period, both counted in timebase ticks.
// Assumes CNT_W is wide enough for BASE_TICKS * 8 * 32.
module conv_timing #(
    parameter int BASE_TICKS = 1,
    parameter int CNT_W      = 9
) (
    input  logic [1:0]       res_i,
    input  logic [1:0]       dly_i,
    output logic [CNT_W-1:0] len_o,
    output logic [CNT_W-1:0] per_o
);
    import conv_pkg::*;

    localparam logic [CNT_W-1:0] BASE_W = CNT_W'(BASE_TICKS);

    // Length doubles per resolution step; period scales the length by the delay code.
    always_comb begin
        len_o = BASE_W << res_i;
        per_o = len_o << dly_shift(dly_i);
    end
endmodule

// File: rtl/conv_seq.sv
// conv_seq: tick-driven conversion sequencer.
// Counts ticks from each conversion start. It flags completion at the end of
// the latched length and restarts at the end of the latched period.
// Shutdown is deferred to a conversion boundary.
// Assumes the inputs presented during reset hold the power-up field values.
module conv_seq #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             shut_req_i,
    input  logic             wake_req_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic [CNT_W-1:0] per_i,
    input  logic [1:0]       res_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [1:0]       res_q_o
);
    import conv_pkg::*;

    seq_st_t          st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] per_q;
    logic [1:0]       res_q;
    logic             pend_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             stop_req;

    // Completion, busy and effective stop request for the current cycle.
    always_comb begin
        cnt_nxt  = cnt_q + 1'b1;
        busy_o   = (st_q == ST_RUN) && (cnt_q < len_q);
        done_o   = (st_q == ST_RUN) && tick_i && (cnt_nxt == len_q);
        stop_req = (pend_q || shut_req_i) && !wake_req_i;
        res_q_o  = res_q;
    end

    // State, tick counter, latched configuration and pending shutdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_RUN;
            cnt_q  <= '0;
            len_q  <= len_i;
            per_q  <= per_i;
            res_q  <= res_i;
            pend_q <= 1'b0;
        end else begin
            case (st_q)
                ST_RUN: begin
                    if (wake_req_i)
                        pend_q <= 1'b0;
                    else if (shut_req_i)
                        pend_q <= 1'b1;
                    if (stop_req && (done_o || !busy_o)) begin
                        st_q   <= ST_SHUT;
                        cnt_q  <= '0;
                        pend_q <= 1'b0;
                    end else if (tick_i) begin
                        if (cnt_nxt == per_q) begin
                            cnt_q <= '0;
                            len_q <= len_i;
                            per_q <= per_i;
                            res_q <= res_i;
                        end else begin
                            cnt_q <= cnt_nxt;
                        end
                    end
                end
                default: begin
                    if (wake_req_i) begin
                        st_q   <= ST_RUN;
                        cnt_q  <= '0;
                        len_q  <= len_i;
                        per_q  <= per_i;
                        res_q  <= res_i;
                        pend_q <= 1'b0;
                    end
                end
            endcase
        end
    end

    AST_SHUT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && busy_o && !done_o) |=> (st_q == ST_RUN)); // R7
    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN) |-> (cnt_q < per_q)); // R3
    AST_WAKE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SHUT && wake_req_i) |=> (busy_o && cnt_q == '0)); // R9
endmodule

// File: rtl/conv_result.sv
// conv_result: captures the raw result on completion, clearing the low bits the
// latched resolution cannot resolve. Raises a one-cycle strobe with it.
// Assumes resolution code 3 means full DATA_W precision.
module conv_result #(
    parameter int DATA_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [1:0]        res_i,
    input  logic [DATA_W-1:0] raw_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] temp_o
);
    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    logic [DATA_W-1:0] keep_mask;
    logic [DATA_W-1:0] temp_q;
    logic              valid_q;

    // Mask keeping only the bits resolved at the latched resolution.
    always_comb keep_mask = ALL_ONES << (2'd3 - res_i);

    // Result register and completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            temp_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= done_i;
            if (done_i)
                temp_q <= raw_i & keep_mask;
        end
    end

    assign temp_o  = temp_q;
    assign valid_o = valid_q;

    AST_TEMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(temp_q)); // R5
    AST_LOW_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> ((temp_q & ~$past(keep_mask)) == '0)); // R4
endmodule

// File: rtl/conv_sched.sv
// conv_sched: resolution-scaled conversion scheduler (top).
// Paces conversions from a slow tick and holds the last completed,
// resolution-masked result. Shutdown is deferred to conversion boundaries.
// Assumes tick_i is a single-cycle pulse from a slow timebase.
module conv_sched #(
    parameter int BASE_TICKS = 1,
    parameter int DATA_W     = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [1:0]        res_sel_i,
    input  logic [1:0]        dly_sel_i,
    input  logic [DATA_W-1:0] raw_i,
    input  logic              shut_req_i,
    input  logic              wake_req_i,
    output logic              busy_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] temp_o
);
    localparam int MAX_PER = BASE_TICKS * 8 * 32;
    localparam int CNT_W   = $clog2(MAX_PER + 1);

    logic [CNT_W-1:0] len_w;
    logic [CNT_W-1:0] per_w;
    logic             done_w;
    logic [1:0]       res_w;

    conv_timing #(.BASE_TICKS(BASE_TICKS), .CNT_W(CNT_W)) u_timing (
        .res_i (res_sel_i),
        .dly_i (dly_sel_i),
        .len_o (len_w),
        .per_o (per_w)
    );

    conv_seq #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .shut_req_i (shut_req_i),
        .wake_req_i (wake_req_i),
        .len_i      (len_w),
        .per_i      (per_w),
        .res_i      (res_sel_i),
        .busy_o     (busy_o),
        .done_o     (done_w),
        .res_q_o    (res_w)
    );

    conv_result #(.DATA_W(DATA_W)) u_result (
        .clk     (clk),
        .rst_n   (rst_n),
        .done_i  (done_w),
        .res_i   (res_w),
        .raw_i   (raw_i),
        .valid_o (valid_o),
        .temp_o  (temp_o)
    );

    AST_STROBE_NOT_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !valid_o); // R1
endmodule

// File: tb/sim_conv_sched.sv
`timescale 1ns/1ps
module sim_conv_sched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        shut = 1'b0;
    logic        wake = 1'b0;
    logic [1:0]  res = 2'd3;
    logic [1:0]  dly = 2'd0;
    logic [12:0] raw = '0;
    logic        busy_o, valid_o;
    logic [12:0] temp_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [12:0] exp_q[$];
    string       tag_q[$];

    // reference model state
    bit m_run;
    bit m_pend;
    int m_cnt, m_len, m_per, m_res;

    conv_sched u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .res_sel_i(res), .dly_sel_i(dly),
        .raw_i(raw), .shut_req_i(shut), .wake_req_i(wake),
        .busy_o(busy_o), .valid_o(valid_o), .temp_o(temp_o)
    );

    always #2 clk = ~clk;

    function automatic int lenf(int r);
        return 1 << r;
    endfunction

    function automatic int perf(int r, int d);
        int m;
        m = (d == 0) ? 1 : (d == 1) ? 2 : (d == 2) ? 4 : 32;
        return lenf(r) * m;
    endfunction

    function automatic logic [12:0] maskf(logic [12:0] v, int r);
        return v & (13'h1FFF << (3 - r));
    endfunction

    task automatic chk(bit ok, string tag, int act, int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic latch_cfg();
        m_res = res;
        m_len = lenf(res);
        m_per = perf(res, dly);
        m_cnt = 0;
    endtask

    task automatic chk_busy(string tag);
        int eb;
        eb = (m_run && m_cnt < m_len) ? 1 : 0;
        chk(busy_o == eb, tag, busy_o, eb);
    endtask

    // driver: one tick; the expected result is queued before the design can produce it
    task automatic do_tick(string tag);
        int nxt;
        @(negedge clk);
        tick = 1'b1;
        if (m_run) begin
            nxt = m_cnt + 1;
            if (nxt == m_len) begin
                exp_q.push_back(maskf(raw, m_res));
                tag_q.push_back(tag);
            end
            if (nxt == m_len && m_pend) begin
                m_run = 0; m_pend = 0; m_cnt = 0;
            end else if (nxt == m_per) begin
                latch_cfg();
            end else begin
                m_cnt = nxt;
            end
        end
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
        chk_busy({tag, " R10 busy"});
    endtask

    task automatic ticks(int n, string tag);
        for (int i = 0; i < n; i++) do_tick(tag);
    endtask

    task automatic do_req(bit s, bit w, string tag);
        @(negedge clk);
        shut = s; wake = w;
        if (w) begin
            if (!m_run) begin m_run = 1; latch_cfg(); end
            m_pend = 0;
        end else if (s && m_run) begin
            if (m_cnt >= m_len) begin m_run = 0; m_cnt = 0; m_pend = 0; end
            else m_pend = 1;
        end
        @(negedge clk);
        shut = 1'b0; wake = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk_busy({tag, " busy"});
    endtask

    task automatic drained(string tag);
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, {tag, " all results delivered"}, exp_q.size(), 0);
    endtask

    // monitor: pops one expectation per strobe; a strobe with nothing queued fails
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R5/R7/R8 unexpected strobe actual=%0h expected=none", temp_o);
            end else begin
                logic [12:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(temp_o == e, {t, " result"}, temp_o, e);
            end
        end
    end

    initial begin
        #400000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        res = 2'd3; dly = 2'd0; raw = '0;
        repeat (3) @(negedge clk);
        latch_cfg(); m_run = 1; m_pend = 0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(temp_o == 0, "R1 temp after reset", temp_o, 0);
        chk(valid_o == 0, "R1 valid after reset", valid_o, 0);
        chk(busy_o == 1, "R1 busy after reset", busy_o, 1);

        // R1/R2: 12-bit conversion needs 8 ticks; register stays 0 meanwhile
        raw = 13'h0190;
        ticks(7, "R2");
        chk(temp_o == 0, "R1 zero before first result", temp_o, 0);
        do_tick("R2 first result");
        drained("R2");

        // R3: continuous mode, busy never drops; negative value unmasked at 12 bits
        raw = 13'h1E70;
        ticks(8, "R3 continuous");
        drained("R3");

        // R6: resolution change mid-conversion applies only from the next start
        raw = 13'h0ABF;
        ticks(3, "R6");
        res = 2'd0;
        ticks(5, "R6 old length and mask");
        ticks(1, "R4 9-bit mask");
        raw = 13'h1FFF;
        ticks(2, "R4 9-bit negative");
        drained("R6");

        // R3/R10: delay x2 at 10 bits leaves an idle gap
        res = 2'd1; dly = 2'd1; raw = 13'h0193;
        ticks(10, "R3 R4 10-bit gap");
        drained("R3 gap");

        // R4: 11-bit mask, delay x4
        res = 2'd2; dly = 2'd2; raw = 13'h0195;
        ticks(12, "R4 11-bit");
        drained("R4 11-bit");

        // R7: shutdown mid-conversion completes the current conversion, then stops
        res = 2'd3; dly = 2'd0; raw = 13'h0C87;
        while (!(m_len == 8 && m_cnt == 0)) do_tick("R7 align");
        ticks(2, "R7 before request");
        do_req(1'b1, 1'b0, "R7 request mid-conversion");
        ticks(6, "R7 final result");
        chk(busy_o == 0, "R7 busy after shutdown", busy_o, 0);
        ticks(5, "R7 quiet");
        drained("R7");

        // R9: wake restarts with current fields; R8: shutdown in the gap is immediate
        res = 2'd0; dly = 2'd3; raw = 13'h1ABF;
        do_req(1'b0, 1'b1, "R9 wake");
        chk(busy_o == 1, "R9 busy after wake", busy_o, 1);
        ticks(1, "R9 result after wake");
        ticks(2, "R8 in gap");
        do_req(1'b1, 1'b0, "R8 request in gap");
        chk(busy_o == 0, "R8 stopped", busy_o, 0);
        ticks(40, "R8 quiet");
        drained("R8");

        // R9: wake then simultaneous wake+shutdown keeps running
        res = 2'd1; dly = 2'd0; raw = 13'h0007;
        do_req(1'b0, 1'b1, "R9 wake again");
        do_req(1'b1, 1'b1, "R9 wake wins");
        chk(busy_o == 1, "R9 still running", busy_o, 1);
        ticks(4, "R9 results continue");
        drained("R9");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule